// File: doc/BRIEF.md
# Descriptor-Chained Memory Fill Engine

This block is a bus master that fills memory regions with a constant word. The work is given as a linked list of descriptors that sit in memory. Software loads the address of the first descriptor into a register and then sets a start bit. The engine reads each descriptor and writes the requested number of bytes of fill data at the destination. It then follows the link word to the next descriptor. The chain ends when a descriptor's link word is zero. While the chain runs, a busy bit in the status register reads 1. Software polls that bit and, once the run is over, reads a sticky error bit, which it clears by writing a one to it.

Each descriptor is eight 32-bit words at consecutive word addresses. The layout is word 0 link, words 1..4 source, word 5 destination, word 6 byte count and word 7 control. The fill value is source word 1, and source words 2..4 are read but not used. The engine keeps only one memory request outstanding. A request stays on the port until the memory raises `mem_ready`. In that same cycle the memory returns read data and an error flag. The memory may hold `mem_ready` low for as long as it needs, and that back-pressure only stalls the engine. While `mem_valid` is high and `mem_ready` is low, the engine keeps the address, direction and write data unchanged.

The register slave is word-wide. It takes writes on `reg_we`, and its read data follows `reg_addr` in the same cycle. It has three registers: control at offset 0x0, status at offset 0x4 and first-descriptor address at offset 0xC.

Top module: `fill_chain_engine`

## Requirements
- R1: After reset the control, status and descriptor-address registers read 0, and `mem_valid` is low. `mem_valid` is never high while the engine is idle.
- R2: Writing 1 to control bit 0 while idle starts a chain at the address held at offset 0xC, with bits 1:0 forced to zero. The engine reads the eight descriptor words in ascending address order. Status bit 10 reads 1 from the start until the chain ends.
- R3: A descriptor with control bits 3:1 equal to 2 and control bit 31 set writes (byte count / 4) words of the fill value (descriptor word 1) at ascending word addresses from the destination. A fill value of zero clears the region.
- R4: A link word (descriptor word 0) of zero ends the chain after that descriptor and no further descriptor is read. A nonzero link word makes the engine fetch the next descriptor at that address.
- R5: A descriptor whose control bit 31 is clear performs no memory writes, and the chain continues with its link.
- R6: A descriptor with a byte count of zero performs no memory writes, and the chain continues with its link.
- R7: If control bits 3:1 are not 2, or the byte count bits 1:0 are nonzero, or the destination bits 1:0 are nonzero, the engine sets status bit 5, makes no writes for that descriptor and ends the chain.
- R8: A memory error response (`mem_err` high with `mem_ready`) on any read or write sets status bit 5 and ends the chain. No further request is issued and the failed write is not retried.
- R9: Writing to status with bit 5 set clears the error bit. Writing with bit 5 clear leaves it unchanged. Status bit 10 is read-only.
- R10: Writing control with bit 0 clear while busy stops the engine. Any request already on the port completes its handshake, then the engine goes idle and issues no further requests.
- R11: A start write while busy is ignored. Rewriting offset 0xC while busy has no effect on the chain in progress, and the new value reads back.
- R12: While `mem_valid` is high and `mem_ready` is low, `mem_addr`, `mem_write` and `mem_wdata` hold steady. Every request address is word-aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_valid | output | 1 | Memory request present |
| mem_ready | input | 1 | Memory accepts request; response valid this cycle |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| mem_err | input | 1 | Error response, valid with `mem_ready` |

## Verification
A wrong descriptor index or wrong captured field shows up at the next handshake. It appears either as a wrong fetch address, or as fill writes with the wrong value, base or length. The bench sees these as mismatches in the memory image and in the read and write counts once busy drops. A sequencer that misses an end condition (null link, error, stop) keeps `mem_valid` high or keeps status bit 10 set. The idle and stop properties flag this one cycle after the triggering handshake, and the bench's busy polling reports it within a few cycles. A lost or stuck error flag is seen on the next status read.

// File: rtl/fill_pkg.sv
package fill_pkg;
  localparam int WORD_W     = 32;
  localparam int DESC_WORDS = 8;
  localparam int IDX_W      = $clog2(DESC_WORDS);
  localparam int REG_AW     = 4;

  // descriptor word positions (walked by the fetch counter)
  localparam int IDX_NEXT = 0;
  localparam int IDX_FILL = 1;
  localparam int IDX_DST  = 5;
  localparam int IDX_CNT  = 6;
  localparam int IDX_CTRL = 7;

  localparam int CTRL_WEN    = 31;
  localparam int CTRL_CMD_LO = 1;
  localparam int CTRL_CMD_HI = CTRL_CMD_LO + 2;
  localparam logic [2:0] CMD_FILL = 3'd2;

  localparam int STAT_ERR  = 5;
  localparam int STAT_BUSY = 10;

  localparam logic [REG_AW-1:0] OFS_CTRL = 4'h0;
  localparam logic [REG_AW-1:0] OFS_STAT = 4'h4;
  localparam logic [REG_AW-1:0] OFS_BASE = 4'hC;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_CHECK, ST_FILL} seq_state_t;

  typedef struct packed {
    logic [WORD_W-1:0] next;
    logic [WORD_W-1:0] fill;
    logic [WORD_W-1:0] dst;
    logic [WORD_W-1:0] cnt;
    logic [WORD_W-1:0] ctrl;
  } desc_t;
endpackage

// File: rtl/fill_regs.sv
module fill_regs
  import fill_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              busy,
  input  logic              err_set,
  output logic              start,
  output logic              stop,
  output logic [WORD_W-1:0] base,
  output logic              err_flag
);
  logic [WORD_W-1:0] base_q;
  logic              err_q;
  logic              wr_ctrl, wr_stat, wr_base;

  assign wr_ctrl = reg_we && (reg_addr == OFS_CTRL);
  assign wr_stat = reg_we && (reg_addr == OFS_STAT);
  assign wr_base = reg_we && (reg_addr == OFS_BASE);

  assign start = wr_ctrl &&  reg_wdata[0] && !busy;
  assign stop  = wr_ctrl && !reg_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (wr_base) base_q <= reg_wdata;
      if (err_set)
        err_q <= 1'b1;
      else if (wr_stat && reg_wdata[STAT_ERR])
        err_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_CTRL: reg_rdata[0] = busy;
      OFS_STAT: begin
        reg_rdata[STAT_BUSY] = busy;
        reg_rdata[STAT_ERR]  = err_q;
      end
      OFS_BASE: reg_rdata = base_q;
      default:  reg_rdata = '0;
    endcase
  end

  assign base     = base_q;
  assign err_flag = err_q;
endmodule

// File: rtl/fill_desc_store.sv
module fill_desc_store
  import fill_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [IDX_W-1:0]  cap_idx,
  input  logic [WORD_W-1:0] cap_word,
  output desc_t             desc
);
  logic [WORD_W-1:0] words [DESC_WORDS];

  // only the fields the sequencer consumes get flops; source words 2..4 are dropped
  for (genvar i = 0; i < DESC_WORDS; i++) begin : g_word
    if (i == IDX_NEXT || i == IDX_FILL || i == IDX_DST || i == IDX_CNT || i == IDX_CTRL) begin : g_keep
      logic [WORD_W-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n)
          q <= '0;
        else if (cap_en && (cap_idx == IDX_W'(i)))
          q <= cap_word;
      end
      assign words[i] = q;
    end else begin : g_drop
      assign words[i] = '0;
    end
  end

  assign desc.next = words[IDX_NEXT];
  assign desc.fill = words[IDX_FILL];
  assign desc.dst  = words[IDX_DST];
  assign desc.cnt  = words[IDX_CNT];
  assign desc.ctrl = words[IDX_CTRL];
endmodule

// File: rtl/fill_seq.sv
module fill_seq
  import fill_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic [WORD_W-1:0] base_in,
  input  desc_t             desc,
  input  logic              mem_ready,
  input  logic              mem_err,
  output logic              mem_valid,
  output logic              mem_write,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              cap_en,
  output logic [IDX_W-1:0]  cap_idx,
  output logic              busy,
  output logic              err_set
);
  localparam int LEFT_W = WORD_W - 2;

  seq_state_t        st, st_nx;
  logic [IDX_W-1:0]  widx;
  logic [WORD_W-1:0] fetch_ptr, dst_ptr, next_ptr;
  logic [LEFT_W-1:0] left;
  logic              stop_pend, stop_now, hs;
  logic              bad_desc, do_fill, chain_end, last_word, last_beat;
  logic              unused_bits;

  assign hs        = mem_valid && mem_ready;
  assign stop_now  = stop || stop_pend;
  assign bad_desc  = (desc.ctrl[CTRL_CMD_HI:CTRL_CMD_LO] != CMD_FILL) ||
                     (desc.cnt[1:0] != 2'b00) || (desc.dst[1:0] != 2'b00);
  assign do_fill   = desc.ctrl[CTRL_WEN] && (desc.cnt[WORD_W-1:2] != '0);
  assign chain_end = (desc.next == '0);
  assign next_ptr  = {desc.next[WORD_W-1:2], 2'b00};
  assign last_word = (widx == IDX_W'(DESC_WORDS - 1));
  assign last_beat = (left == LEFT_W'(1));
  assign unused_bits = ^{desc.ctrl[WORD_W-2:CTRL_CMD_HI+1], desc.ctrl[0], base_in[1:0]};

  always_comb begin
    st_nx   = st;
    err_set = 1'b0;
    case (st)
      ST_IDLE:  if (start) st_nx = ST_FETCH;
      ST_FETCH: if (hs) begin
        if (mem_err) begin
          err_set = 1'b1;
          st_nx   = ST_IDLE;
        end else if (stop_now) st_nx = ST_IDLE;
        else if (last_word)    st_nx = ST_CHECK;
      end
      ST_CHECK: begin
        if (stop_now) st_nx = ST_IDLE;
        else if (bad_desc) begin
          err_set = 1'b1;
          st_nx   = ST_IDLE;
        end else if (do_fill)  st_nx = ST_FILL;
        else if (chain_end)    st_nx = ST_IDLE;
        else                   st_nx = ST_FETCH;
      end
      ST_FILL: if (hs) begin
        if (mem_err) begin
          err_set = 1'b1;
          st_nx   = ST_IDLE;
        end else if (stop_now) st_nx = ST_IDLE;
        else if (last_beat)    st_nx = chain_end ? ST_IDLE : ST_FETCH;
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      widx      <= '0;
      fetch_ptr <= '0;
      dst_ptr   <= '0;
      left      <= '0;
      stop_pend <= 1'b0;
    end else begin
      st        <= st_nx;
      stop_pend <= (st_nx != ST_IDLE) && stop_now;
      case (st)
        ST_IDLE: if (start) begin
          fetch_ptr <= {base_in[WORD_W-1:2], 2'b00};
          widx      <= '0;
        end
        ST_FETCH: if (hs && !mem_err) widx <= last_word ? '0 : widx + 1'b1;
        ST_CHECK: begin
          dst_ptr <= desc.dst;
          left    <= desc.cnt[WORD_W-1:2];
          if (!do_fill) begin
            fetch_ptr <= next_ptr;
            widx      <= '0;
          end
        end
        ST_FILL: if (hs) begin
          dst_ptr <= dst_ptr + WORD_W'(4);
          left    <= left - 1'b1;
          if (last_beat) begin
            fetch_ptr <= next_ptr;
            widx      <= '0;
          end
        end
        default: ;
      endcase
    end
  end

  assign mem_valid = (st == ST_FETCH) || (st == ST_FILL);
  assign mem_write = (st == ST_FILL);
  assign mem_addr  = (st == ST_FILL) ? dst_ptr
                   : fetch_ptr + {{(WORD_W-IDX_W-2){1'b0}}, widx, 2'b00};
  assign mem_wdata = (st == ST_FILL) ? desc.fill : '0;
  assign cap_en    = (st == ST_FETCH) && hs && !mem_err;
  assign cap_idx   = widx;
  assign busy      = (st != ST_IDLE);
endmodule

// File: rtl/fill_chain_engine.sv
module fill_chain_engine
  import fill_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_err
);
  logic              busy_w, err_set_w, start_w, stop_w, err_flag_w, cap_en_w;
  logic [WORD_W-1:0] base_w;
  logic [IDX_W-1:0]  cap_idx_w;
  desc_t             desc_w;

  fill_regs u_regs (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .busy(busy_w), .err_set(err_set_w), .start(start_w), .stop(stop_w),
    .base(base_w), .err_flag(err_flag_w)
  );

  fill_desc_store u_store (
    .clk, .rst_n, .cap_en(cap_en_w), .cap_idx(cap_idx_w),
    .cap_word(mem_rdata), .desc(desc_w)
  );

  fill_seq u_seq (
    .clk, .rst_n, .start(start_w), .stop(stop_w), .base_in(base_w),
    .desc(desc_w), .mem_ready, .mem_err, .mem_valid, .mem_write,
    .mem_addr, .mem_wdata, .cap_en(cap_en_w), .cap_idx(cap_idx_w),
    .busy(busy_w), .err_set(err_set_w)
  );
endmodule

// File: rtl/fill_chain_chk.sv
module fill_chain_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_valid,
  input logic        mem_ready,
  input logic        mem_write,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_err,
  input logic        busy,
  input logic        err_set,
  input logic        err_flag,
  input logic        stop,
  input logic        clr_req
);
  // R12
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata));

  // R12
  aligned_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_addr[1:0] == 2'b00);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_valid);

  // R8
  err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready && mem_err |=> !busy && !mem_valid);

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |=> err_flag);

  // R9
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req && !err_set |=> !err_flag);

  // R10
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && stop && (!mem_valid || mem_ready) |=> !busy);
endmodule

bind fill_chain_engine fill_chain_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_err(mem_err), .busy(busy_w), .err_set(err_set_w),
  .err_flag(err_flag_w), .stop(stop_w),
  .clr_req(reg_we && (reg_addr == fill_pkg::OFS_STAT) && reg_wdata[fill_pkg::STAT_ERR])
);

// File: tb/test_fill_chain_engine.sv
`timescale 1ns/1ps
module test_fill_chain_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_valid, mem_ready, mem_write, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  always #2.5 clk = ~clk;

  fill_chain_engine i_fill_chain_engine (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .mem_valid, .mem_ready, .mem_write, .mem_addr, .mem_wdata,
    .mem_rdata, .mem_err
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [31:0] mem [0:255];
  logic [31:0] exp_mem [0:255];
  int lat_cnt, lat_need, wr_count, rd_count;
  logic err_on;
  logic [31:0] err_addr;

  // memory model: ready after 0..2 extra cycles, response in the ready cycle
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ready <= 1'b0; mem_err <= 1'b0; mem_rdata <= '0;
      lat_cnt <= 0; lat_need <= 0;
    end else if (mem_ready) begin
      mem_ready <= 1'b0; mem_err <= 1'b0; lat_cnt <= 0;
      if (mem_valid && mem_write && !mem_err) begin
        mem[mem_addr[9:2]] <= mem_wdata;
        wr_count <= wr_count + 1;
      end
      if (mem_valid && !mem_write) rd_count <= rd_count + 1;
    end else if (mem_valid) begin
      if (lat_cnt >= lat_need) begin
        mem_ready <= 1'b1;
        mem_err   <= err_on && (mem_addr == err_addr);
        mem_rdata <= mem[mem_addr[9:2]];
        lat_need  <= (lat_need + 1) % 3;
      end else lat_cnt <= lat_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_we = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle(output logic [31:0] s);
    int n = 0;
    do begin reg_read(4'h4, s); n++; end while (s[10] && n < 20000);
  endtask

  task automatic init_mem();
    for (int i = 0; i < 256; i++) begin
      mem[i] = 32'hA5A5_0000 | i; exp_mem[i] = 32'hA5A5_0000 | i;
    end
  endtask

  task automatic put_desc(input int a, input logic [31:0] nxt, fill, dst, cnt, ctrl);
    logic [31:0] w [8];
    w[0] = nxt; w[1] = fill; w[2] = 32'h5EED_0002; w[3] = 32'h5EED_0003;
    w[4] = 32'h5EED_0004; w[5] = dst; w[6] = cnt; w[7] = ctrl;
    for (int k = 0; k < 8; k++) begin
      mem[(a >> 2) + k] = w[k]; exp_mem[(a >> 2) + k] = w[k];
    end
  endtask

  task automatic exp_fill(input int dst, input int nw, input logic [31:0] fill);
    for (int k = 0; k < nw; k++) exp_mem[(dst >> 2) + k] = fill;
  endtask

  task automatic cmp_mem(input string req);
    int bad = 0;
    logic [31:0] a = '0, e = '0;
    for (int i = 0; i < 256; i++)
      if (mem[i] !== exp_mem[i]) begin
        if (bad == 0) begin a = mem[i]; e = exp_mem[i]; end
        bad++;
      end
    check(bad == 0, req, a, e);
  endtask

  task automatic run(input logic [31:0] first, output logic [31:0] s);
    wr_count = 0; rd_count = 0;
    reg_write(4'hC, first);
    reg_write(4'h0, 32'h1);
    wait_idle(s);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired (R2): actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] s, fill, ctrl;
    int dst, k;
    reg_we = 0; reg_addr = 0; reg_wdata = 0; err_on = 0; err_addr = 0;
    wr_count = 0; rd_count = 0;
    rst_n = 0;
    init_mem();
    repeat (4) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    check(mem_valid == 1'b0, "R1 mem_valid", {31'b0, mem_valid}, 0);
    reg_read(4'h0, s); check(s == 0, "R1 ctrl", s, 0);
    reg_read(4'h4, s); check(s == 0, "R1 status", s, 0);
    reg_read(4'hC, s); check(s == 0, "R1 base", s, 0);

    // R3 / R6 sweep of length and destination offset, single descriptor
    for (int cw = 0; cw <= 8; cw++)
      for (int off = 0; off < 4; off++) begin
        init_mem();
        fill = (off == 3) ? 32'h0 : (32'h0101_0101 * (cw + 1)) ^ (off << 28);
        dst = 32'h100 + off * 4 + cw * 8;
        put_desc(0, 0, fill, dst, cw * 4, 32'h8000_0004);
        exp_fill(dst, cw, fill);
        run(32'h0, s);
        check(s == 0, "R3 status", s, 0);
        cmp_mem(cw == 0 ? "R6 image" : "R3 image");
        check(wr_count == cw, cw == 0 ? "R6 writes" : "R3 writes", wr_count, cw);
        check(rd_count == 8, "R4 null link reads", rd_count, 8);
      end

    // R4 R5 R6 chain of four descriptors
    init_mem();
    put_desc(32'h00, 32'h40, 32'h1111_2222, 32'h100, 32, 32'h8000_0004);
    put_desc(32'h40, 32'h80, 32'h3333_4444, 32'h200, 64, 32'h0000_0004);
    put_desc(32'h80, 32'hC0, 32'h5555_6666, 32'h280, 0, 32'h8000_0004);
    put_desc(32'hC0, 32'h0,  32'h7777_8888, 32'h300, 20, 32'h8000_0004);
    exp_fill(32'h100, 8, 32'h1111_2222);
    exp_fill(32'h300, 5, 32'h7777_8888);
    run(32'h1, s);  // low bits of base ignored (R2)
    check(s == 0, "R4 chain status", s, 0);
    cmp_mem("R5 chain image");
    check(wr_count == 13, "R5 chain writes", wr_count, 13);
    check(rd_count == 32, "R4 chain reads", rd_count, 32);

    // R7 command code sweep
    for (int cmd = 0; cmd < 8; cmd++) begin
      init_mem();
      ctrl = 32'h8000_0000 | (cmd << 1);
      put_desc(32'h00, 32'h40, 32'hCAFE_0000 | cmd, 32'h100, 8, ctrl);
      put_desc(32'h40, 32'h0, 32'hBEEF_0000 | cmd, 32'h200, 8, 32'h8000_0004);
      if (cmd == 2) begin
        exp_fill(32'h100, 2, 32'hCAFE_0002);
        exp_fill(32'h200, 2, 32'hBEEF_0002);
      end
      run(32'h0, s);
      check(s == (cmd == 2 ? 32'h0 : 32'h20), "R7 cmd status", s, cmd == 2 ? 32'h0 : 32'h20);
      cmp_mem("R7 cmd image");
      check(rd_count == (cmd == 2 ? 16 : 8), "R7 cmd reads", rd_count, cmd == 2 ? 16 : 8);
      reg_write(4'h4, s);
      reg_read(4'h4, s); check(s == 0, "R9 clear by write-back", s, 0);
    end

    // R7 misaligned count, misaligned destination
    for (int v = 0; v < 2; v++) begin
      init_mem();
      put_desc(0, 0, 32'h1234_5678, v == 0 ? 32'h100 : 32'h102, v == 0 ? 6 : 8, 32'h8000_0004);
      run(32'h0, s);
      check(s == 32'h20, "R7 alignment status", s, 32'h20);
      check(wr_count == 0, "R7 alignment writes", wr_count, 0);
      cmp_mem("R7 alignment image");
      // R9 writing zero keeps the flag, writing bit 5 clears it
      reg_write(4'h4, 32'h0);
      reg_read(4'h4, s); check(s == 32'h20, "R9 write zero keeps", s, 32'h20);
      reg_write(4'h4, 32'hFFFF_FFFF);
      reg_read(4'h4, s); check(s == 0, "R9 clear", s, 0);
    end

    // R8 error on a fill write
    init_mem();
    put_desc(32'h00, 32'h40, 32'h0F0F_0F0F, 32'h100, 16, 32'h8000_0004);
    put_desc(32'h40, 32'h0, 32'h1, 32'h200, 8, 32'h8000_0004);
    exp_fill(32'h100, 2, 32'h0F0F_0F0F);
    err_on = 1; err_addr = 32'h108;
    run(32'h0, s);
    err_on = 0;
    check(s == 32'h20, "R8 write error status", s, 32'h20);
    check(wr_count == 2, "R8 write error writes", wr_count, 2);
    check(rd_count == 8, "R8 write error reads", rd_count, 8);
    cmp_mem("R8 write error image");
    check(mem_valid == 1'b0, "R8 port quiet", {31'b0, mem_valid}, 0);
    reg_write(4'h4, 32'h20);

    // R8 error on a descriptor read
    init_mem();
    put_desc(32'h00, 32'h40, 32'h2222_0000, 32'h100, 8, 32'h8000_0004);
    put_desc(32'h40, 32'h0, 32'h3333_0000, 32'h200, 12, 32'h8000_0004);
    exp_fill(32'h100, 2, 32'h2222_0000);
    err_on = 1; err_addr = 32'h54;
    run(32'h0, s);
    err_on = 0;
    check(s == 32'h20, "R8 fetch error status", s, 32'h20);
    check(rd_count == 14, "R8 fetch error reads", rd_count, 14);
    cmp_mem("R8 fetch error image");
    reg_write(4'h4, 32'h20);

    // R10 stop in the middle of a long fill
    init_mem();
    put_desc(32'h00, 32'h40, 32'h6666_7777, 32'h100, 256, 32'h8000_0004);
    put_desc(32'h40, 32'h0, 32'h8888_9999, 32'h300, 8, 32'h8000_0004);
    wr_count = 0; rd_count = 0;
    reg_write(4'hC, 32'h0);
    reg_write(4'h0, 32'h1);
    repeat (50) @(negedge clk);
    reg_write(4'h0, 32'h0);
    k = 0;
    do begin reg_read(4'h4, s); k++; end while (s[10] && k < 8);
    check(s[10] == 1'b0, "R10 stop idle", s, 0);
    repeat (10) @(negedge clk);
    k = 0;
    while (k < 64 && mem[(32'h100 >> 2) + k] == 32'h6666_7777) k++;
    check(k > 0 && k < 64, "R10 partial length", k, 32);
    check(wr_count == k, "R10 no write after stop", wr_count, k);
    exp_fill(32'h100, k, 32'h6666_7777);
    cmp_mem("R10 stop image");
    check(rd_count == 8, "R10 no fetch after stop", rd_count, 8);

    // R11 start and base rewrite while busy
    init_mem();
    put_desc(32'h00, 32'h0, 32'hABCD_0001, 32'h100, 64, 32'h8000_0004);
    put_desc(32'h40, 32'h0, 32'hABCD_0002, 32'h200, 64, 32'h8000_0004);
    exp_fill(32'h100, 16, 32'hABCD_0001);
    wr_count = 0; rd_count = 0;
    reg_write(4'hC, 32'h0);
    reg_write(4'h0, 32'h1);
    repeat (10) @(negedge clk);
    reg_read(4'h4, s); check(s == 32'h400, "R2 busy while running", s, 32'h400);
    reg_read(4'h0, s); check(s == 32'h1, "R2 ctrl while running", s, 32'h1);
    reg_write(4'hC, 32'h40);
    reg_write(4'h0, 32'h1);
    wait_idle(s);
    check(s == 0, "R11 status", s, 0);
    check(wr_count == 16, "R11 writes", wr_count, 16);
    check(rd_count == 8, "R11 reads", rd_count, 8);
    cmp_mem("R11 image");
    reg_read(4'hC, s); check(s == 32'h40, "R11 base readback", s, 32'h40);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule